// File: doc/BRIEF.md
# Serial Clock and Chip-Select Timing Generator

This block drives the serial clock and the chip-select pin of a flash-fetch SPI master. It runs entirely in the system clock domain. A sequencer upstream asks for a burst of clock pulses. The block asserts chip-select, waits a programmable lead time, and then emits the pulses. Each pulse has a low phase and a high phase, and the length of each phase is programmable. When the last pulse ends, the block raises a one-cycle done strobe.

After a burst, chip-select stays asserted so that a following access can start at once. A retriggerable idle timer releases chip-select when no new request arrives in time. Once chip-select is released, it stays inactive for a programmable minimum time before it can assert again. The SPI mode selects the level at which the clock idles. Chip-select polarity is also programmable. Only one chip-select line exists.

Top module: `spi_sclk_cs_gen`

## Requirements
- R1: After reset, `sclk` equals `mode3`, `cs_pin` is at its inactive level, `ready` is 1 and `pulse_done` is 0.
- R2: With `mode3`=0 the clock idles low. With `mode3`=1 it idles high. Every pulse is a low phase followed by a high phase.
- R3: The low phase lasts `lo_time` system clocks and the high phase lasts `hi_time` system clocks. A value of 0 counts as 1.
- R4: With `cs_act_high`=1, `cs_pin` is 1 while chip-select is asserted. With `cs_act_high`=0 it is 0 while asserted.
- R5: A request accepted while chip-select is inactive asserts chip-select in the next cycle. The first low phase then starts after a lead of 0, 2, 4 or 8 cycles, for `lead_sel` = 0, 1, 2 or 3.
- R6: Once released, chip-select stays inactive for at least 1, 3, 5 or 9 cycles, for `trail_sel` = 0, 1, 2 or 3. `ready` stays 0 until a request accepted in that cycle would meet this minimum.
- R7: A request with `pulse_num`=N produces N pulses, and N=0 counts as 1. `pulse_done` is 1 for exactly the one cycle that follows the end of the last high phase.
- R8: After the done strobe, chip-select stays asserted and `ready` is 1. A request accepted in this hold period starts a low phase in the next cycle, with no lead time.
- R9: If no request arrives during the hold period, chip-select is released after `idle_limit` hold cycles, and a value of 0 counts as 1. Each accepted request restarts this timer.
- R10: `pulse_req` has no effect while `ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode3 | input | 1 | 1 selects SPI mode 3 (clock idles high); 0 selects mode 0 (clock idles low) |
| cs_act_high | input | 1 | 1 makes chip-select active high |
| lo_time | input | PH_W | Low-phase length in system clocks |
| hi_time | input | PH_W | High-phase length in system clocks |
| lead_sel | input | 2 | Lead-time code |
| trail_sel | input | 2 | Minimum inactive-time code |
| idle_limit | input | IDLE_W | Hold cycles before chip-select is released |
| pulse_req | input | 1 | One-cycle request strobe, taken when `ready` is 1 |
| pulse_num | input | NUM_W | Number of pulses for the request |
| sclk | output | 1 | Serial clock |
| cs_pin | output | 1 | Chip-select pin level |
| ready | output | 1 | A request in this cycle would be accepted |
| pulse_done | output | 1 | One-cycle strobe after the last pulse |

## Verification
The assertions assume that the configuration inputs stay constant while chip-select is asserted. The phase-length and lead checks compare measured lengths against the current settings, so a change in the middle of a burst would trip them falsely. The bench therefore changes configuration only while reset is held. Requests are sometimes driven while `ready` is low and sometimes held over several cycles, so that ignored strobes and exact acceptance cycles are both exercised.

// File: rtl/spi_sclk_cs_gen.sv
module spi_sclk_cs_gen #(
  parameter int PH_W   = 4,
  parameter int IDLE_W = 16,
  parameter int NUM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode3,
  input  logic              cs_act_high,
  input  logic [PH_W-1:0]   lo_time,
  input  logic [PH_W-1:0]   hi_time,
  input  logic [1:0]        lead_sel,
  input  logic [1:0]        trail_sel,
  input  logic [IDLE_W-1:0] idle_limit,
  input  logic              pulse_req,
  input  logic [NUM_W-1:0]  pulse_num,
  output logic              sclk,
  output logic              cs_pin,
  output logic              ready,
  output logic              pulse_done
);
  localparam int CW = PH_W + 1;
  localparam int RW = IDLE_W + 1;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_LO, S_HI, S_HOLD} st_t;

  st_t              state;
  logic [CW-1:0]    cnt, trail_cnt, lead_n, trail_n, lo_eff, hi_eff;
  logic [IDLE_W-1:0] idle_cnt, idle_eff;
  logic [NUM_W-1:0] left, left_init;
  logic             cs_act, accept;

  assign lo_eff    = (lo_time == '0) ? CW'(1) : {1'b0, lo_time};
  assign hi_eff    = (hi_time == '0) ? CW'(1) : {1'b0, hi_time};
  assign idle_eff  = (idle_limit == '0) ? IDLE_W'(1) : idle_limit;
  assign left_init = (pulse_num == '0) ? '0 : pulse_num - 1'b1;

  always_comb begin
    case (lead_sel)
      2'd0:    lead_n = CW'(0);
      2'd1:    lead_n = CW'(2);
      2'd2:    lead_n = CW'(4);
      default: lead_n = CW'(8);
    endcase
    case (trail_sel)
      2'd0:    trail_n = CW'(1);
      2'd1:    trail_n = CW'(3);
      2'd2:    trail_n = CW'(5);
      default: trail_n = CW'(9);
    endcase
  end

  assign cs_act = (state != S_IDLE);
  assign ready  = (state == S_HOLD) || (state == S_IDLE && trail_cnt == '0);
  assign accept = pulse_req && ready;
  assign sclk   = (state == S_HI) || (state != S_LO && mode3);
  assign cs_pin = cs_act_high ? cs_act : ~cs_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      trail_cnt  <= '0;
      idle_cnt   <= '0;
      left       <= '0;
      pulse_done <= 1'b0;
    end else begin
      pulse_done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (trail_cnt != '0) trail_cnt <= trail_cnt - 1'b1;
          if (accept) begin
            left <= left_init;
            if (lead_n != '0) begin
              state <= S_LEAD;
              cnt   <= lead_n - 1'b1;
            end else begin
              state <= S_LO;
              cnt   <= lo_eff - 1'b1;
            end
          end
        end
        S_LEAD: begin
          if (cnt == '0) begin
            state <= S_LO;
            cnt   <= lo_eff - 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        S_LO: begin
          if (cnt == '0) begin
            state <= S_HI;
            cnt   <= hi_eff - 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        S_HI: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (left == '0) begin
            state      <= S_HOLD;
            idle_cnt   <= '0;
            pulse_done <= 1'b1;
          end else begin
            left  <= left - 1'b1;
            state <= S_LO;
            cnt   <= lo_eff - 1'b1;
          end
        end
        S_HOLD: begin
          if (accept) begin
            left  <= left_init;
            state <= S_LO;
            cnt   <= lo_eff - 1'b1;
          end else if (({1'b0, idle_cnt} + 1'b1) >= {1'b0, idle_eff}) begin
            state     <= S_IDLE;
            trail_cnt <= trail_n - 1'b1;
          end else idle_cnt <= idle_cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  st_t           last_state;
  logic [RW-1:0] run, cur_len;
  logic [4:0]    gap;

  assign cur_len = (state == last_state) ? ((&run) ? run : run + 1'b1) : RW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_state <= S_IDLE;
      run        <= RW'(1);
      gap        <= '1;
    end else begin
      last_state <= state;
      run        <= cur_len;
      gap        <= cs_act ? '0 : ((&gap) ? gap : gap + 1'b1);
    end
  end

  p_lo_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (last_state == S_LO && state != S_LO) |-> run == RW'(lo_eff));
  p_hi_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (last_state == S_HI && state != S_HI) |-> run == RW'(hi_eff));
  p_idle_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE || state == S_LEAD || state == S_HOLD) |-> sclk == mode3);
  p_trail_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_act) |-> gap >= 5'(trail_n));
  p_done_after_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_done |-> (state == S_HOLD && last_state == S_HI));
  p_hold_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HOLD) |-> cur_len <= {1'b0, idle_eff});
  p_lead_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (last_state == S_LEAD && state != S_LEAD) |-> run == RW'(lead_n));
endmodule

// File: tb/sim_spi_sclk_cs_gen.sv
module sim_spi_sclk_cs_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode3 = 1'b0, cs_act_high = 1'b0;
  logic [3:0] lo_time = 4'd2, hi_time = 4'd3;
  logic [1:0] lead_sel = 2'd1, trail_sel = 2'd2;
  logic [15:0] idle_limit = 16'd6;
  logic pulse_req = 1'b0;
  logic [7:0] pulse_num = 8'd0;
  logic sclk, cs_pin, ready, pulse_done;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  spi_sclk_cs_gen u0 (
    .clk(clk), .rst_n(rst_n), .mode3(mode3), .cs_act_high(cs_act_high),
    .lo_time(lo_time), .hi_time(hi_time), .lead_sel(lead_sel), .trail_sel(trail_sel),
    .idle_limit(idle_limit), .pulse_req(pulse_req), .pulse_num(pulse_num),
    .sclk(sclk), .cs_pin(cs_pin), .ready(ready), .pulse_done(pulse_done));

  // reference: 0 off, 1 lead, 2 low, 3 high, 4 hold; counters count up
  int m_mode, m_t, m_sent, m_target, m_idle, m_gap;
  bit m_done;

  function automatic int lead_of(input logic [1:0] c);
    return (c == 0) ? 0 : (1 << c);
  endfunction
  function automatic int trail_of(input logic [1:0] c);
    return (c == 0) ? 1 : (1 << c) + 1;
  endfunction
  function automatic int nz(input int v);
    return (v == 0) ? 1 : v;
  endfunction
  function automatic bit m_ready();
    return (m_mode == 4) || (m_mode == 0 && m_gap >= trail_of(trail_sel) - 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_t = 0; m_sent = 0; m_target = 1; m_idle = 0; m_gap = 1000; m_done = 0;
    end else begin
      bit acc;
      acc = pulse_req && m_ready();
      m_done = 0;
      case (m_mode)
        0: begin
          if (m_gap < 1000) m_gap++;
          if (acc) begin
            m_target = nz(pulse_num); m_sent = 0; m_t = 0;
            m_mode = (lead_of(lead_sel) > 0) ? 1 : 2;
          end
        end
        1: if (m_t + 1 == lead_of(lead_sel)) begin m_mode = 2; m_t = 0; end else m_t++;
        2: if (m_t + 1 == nz(lo_time)) begin m_mode = 3; m_t = 0; end else m_t++;
        3: if (m_t + 1 == nz(hi_time)) begin
             m_t = 0; m_sent++;
             if (m_sent == m_target) begin m_mode = 4; m_idle = 0; m_done = 1; end
             else m_mode = 2;
           end else m_t++;
        default: begin
          if (acc) begin m_target = nz(pulse_num); m_sent = 0; m_t = 0; m_mode = 2; end
          else if (m_idle + 1 >= nz(idle_limit)) begin m_mode = 0; m_gap = 0; end
          else m_idle++;
        end
      endcase
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", cur_req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("sclk R2/R3", sclk, (m_mode == 3) || (m_mode != 2 && mode3));
      chk("cs_pin R4/R5/R9", cs_pin, cs_act_high ? (m_mode != 0) : (m_mode == 0));
      chk("ready R6/R8/R10", ready, m_ready());
      chk("pulse_done R7", pulse_done, m_done);
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send(input int n);
    while (!ready) @(negedge clk);
    pulse_req = 1'b1; pulse_num = 8'(n);
    @(negedge clk);
    pulse_req = 1'b0;
  endtask

  task automatic wait_mode(input int md);
    while (m_mode != md) @(negedge clk);
  endtask

  task automatic stray_req();
    // R10: a strobe while busy must change nothing
    while (ready) @(negedge clk);
    pulse_req = 1'b1; pulse_num = 8'd9;
    @(negedge clk);
    pulse_req = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    cur_req = "R1";
    chk("reset sclk R1", sclk, 0);
    chk("reset cs_pin R1", cs_pin, 1);
    chk("reset ready R1", ready, 1);
    chk("reset done R1", pulse_done, 0);

    cur_req = "R3 R5 R7";
    send(3);
    cur_req = "R10";
    stray_req();
    wait_mode(4);
    cur_req = "R8";
    send(2);
    wait_mode(4);
    cur_req = "R9";
    wait_mode(0);
    cur_req = "R6";
    pulse_req = 1'b1; pulse_num = 8'd1;
    while (m_mode == 0) @(negedge clk);
    pulse_req = 1'b0;
    wait_mode(0);
    repeat (12) @(negedge clk);

    mode3 = 1'b1; cs_act_high = 1'b1; lo_time = 4'd0; hi_time = 4'd0;
    lead_sel = 2'd3; trail_sel = 2'd3; idle_limit = 16'd0;
    do_reset();
    @(negedge clk);
    cur_req = "R1 R2 R4";
    chk("reset sclk mode3 R1", sclk, 1);
    chk("reset cs_pin high-active R4", cs_pin, 0);
    cur_req = "R2 R3 R5 R7";
    send(0);
    wait_mode(4);
    cur_req = "R8";
    send(4);
    cur_req = "R10";
    stray_req();
    wait_mode(0);
    cur_req = "R6";
    pulse_req = 1'b1; pulse_num = 8'd2;
    while (m_mode == 0) @(negedge clk);
    pulse_req = 1'b0;
    wait_mode(0);
    repeat (12) @(negedge clk);

    mode3 = 1'b0; cs_act_high = 1'b0; lo_time = 4'd15; hi_time = 4'd1;
    lead_sel = 2'd0; trail_sel = 2'd0; idle_limit = 16'd1;
    do_reset();
    cur_req = "R5 R6 R9";
    for (int i = 0; i < 4; i++) begin
      send(2);
      wait_mode(4);
      if (i % 2 == 1) wait_mode(0);
    end
    wait_mode(0);
    send(1);
    wait_mode(0);
    lead_sel = 2'd2; trail_sel = 2'd1; idle_limit = 16'd300;
    do_reset();
    cur_req = "R5 R9";
    send(1);
    wait_mode(0);
    repeat (5) @(negedge clk);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule